// File: doc/BRIEF.md
# Single-Clock FIFO with Reset-Busy Handshake

This block is a single-clock first-in first-out buffer whose synchronous reset is not an instant clear. Instead, reset launches a short, fixed sequence that the block reports on two busy outputs, one for the producer side and one for the consumer side. A producer uses its busy flag to know when pushing is allowed again. A consumer uses its busy flag, plus a fixed tail of extra quiet cycles, to know when popping is allowed again. During the sequence the pointers and the occupancy count return to zero.

Data moves through plain strobe ports. The producer presents a word and raises the write strobe. `full` is the back-pressure signal: a strobe raised while `full` is high is dropped. The consumer sees the head word on `rd_data` as long as `empty` is low, and raises the read strobe to remove it. A strobe raised while `empty` is high is dropped. A one-cycle error pulse reports any strobe that arrives inside its forbidden reset window. Such a strobe is also ignored, so a careless user cannot corrupt the state that reset has just cleared.

Top module: `rstbusy_fifo`

## Requirements
- R1: `wr_busy` and `rd_busy` carry the same value in every cycle.
- R2: In each cycle, both busy outputs equal the value `srst` had in the previous cycle, however long `srst` is held.
- R3: In the cycle after `srst` is sampled high, `level` is 0, `empty` is 1 and `full` is 0.
- R4: The write window covers every cycle in which `srst` or `wr_busy` is high, plus the first cycle in which busy is low again. A write strobe sampled inside this window stores nothing, and `proto_err` is 1 in the next cycle.
- R5: The read window is the write window plus the two cycles that follow it. A read strobe sampled inside this window removes nothing, and `proto_err` is 1 in the next cycle.
- R6: When neither strobe was sampled inside its window, `proto_err` is 0 in the next cycle.
- R7: Words leave in the order they were accepted. While `empty` is 0, `rd_data` shows the oldest stored word.
- R8: `full` is 1 exactly when `level` equals DEPTH. A write sampled while `full` is 1 is dropped, even if a read is accepted in the same cycle.
- R9: `empty` is 1 exactly when `level` is 0. A read sampled while `empty` is 1 is dropped, and `level` stays 0.
- R10: When a read and a write are both accepted in one cycle, `level` does not change.
- R11: `level` reports the number of stored words, from 0 to DEPTH. It rises by one for each accepted write and falls by one for each accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset request, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry (back-pressure) |
| rd_en | input | 1 | Read strobe, removes the head word |
| rd_data | output | DATA_W | Head word, valid while empty is low |
| empty | output | 1 | No stored word |
| level | output | $clog2(DEPTH)+1 | Number of stored words |
| wr_busy | output | 1 | Write side still resetting |
| rd_busy | output | 1 | Read side still resetting |
| proto_err | output | 1 | One-cycle pulse after a strobe inside its window |

## Verification
A stuck or stale window counter shows up at the ports within a few cycles. A strobe placed one cycle past a window edge either raises `proto_err` when it should not, or stays silent when it should fire. The same strobe also moves `level` when it should not, or fails to move it. Pointer or wrap-bit faults appear as a wrong `level`, a wrong `full` or `empty`, or a head word out of order. These show up no later than the first wrap of the buffer, which happens within DEPTH accepted writes. A reset that fails to clear the pointers is visible in the very next cycle through `level` and `empty`.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  // Extra quiet cycles the read side needs beyond the write-side window.
  localparam int unsigned RD_TAIL_DEFAULT = 2;

  // Per-side blocking decisions produced by the reset sequencer.
  typedef struct packed {
    logic wr_block;
    logic rd_block;
  } gate_t;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/rbf_reset_seq.sv
module rbf_reset_seq #(
  parameter int unsigned RD_TAIL = rbf_pkg::RD_TAIL_DEFAULT
) (
  input  logic           clk,
  input  logic           srst,
  input  logic           wr_en,
  input  logic           rd_en,
  output logic           busy,
  output rbf_pkg::gate_t gate,
  output logic           proto_err
);
  localparam int unsigned CW = $clog2(RD_TAIL + 2);
  localparam logic [CW-1:0] LOAD = CW'(RD_TAIL + 1);

  logic          busy_q;
  logic [CW-1:0] quiet_q;
  logic          err_q;
  logic          in_reset;

  assign in_reset = srst | busy_q;

  // Busy is the reset request delayed by one cycle.
  always_ff @(posedge clk) begin
    busy_q <= srst;
  end

  // Counts the cycles after busy drops. The first one still blocks writes,
  // and the following RD_TAIL cycles still block reads.
  always_ff @(posedge clk) begin
    if (in_reset) begin
      quiet_q <= LOAD;
    end else if (quiet_q != '0) begin
      quiet_q <= quiet_q - 1'b1;
    end
  end

  always_comb begin
    gate.wr_block = in_reset | (quiet_q == LOAD);
    gate.rd_block = in_reset | (quiet_q != '0);
  end

  always_ff @(posedge clk) begin
    err_q <= (wr_en & gate.wr_block) | (rd_en & gate.rd_block);
  end

  assign busy      = busy_q;
  assign proto_err = err_q;
endmodule

// File: rtl/rbf_ptr_ctrl.sv
module rbf_ptr_ctrl #(
  parameter int unsigned AW = 4
) (
  input  logic           clk,
  input  logic           srst,
  input  logic           wr_req,
  input  logic           rd_req,
  input  rbf_pkg::gate_t gate,
  output logic           wr_fire,
  output logic [AW-1:0]  waddr,
  output logic [AW-1:0]  raddr,
  output logic           full,
  output logic           empty,
  output logic [AW:0]    level
);
  logic [AW:0] wp_q;
  logic [AW:0] rp_q;
  logic        rd_fire;

  always_comb begin
    empty   = (wp_q == rp_q);
    full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    wr_fire = wr_req & ~gate.wr_block & ~full;
    rd_fire = rd_req & ~gate.rd_block & ~empty;
    level   = wp_q - rp_q;
    waddr   = wp_q[AW-1:0];
    raddr   = rp_q[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_fire) wp_q <= wp_q + 1'b1;
      if (rd_fire) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/rbf_store.sv
module rbf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rstbusy_fifo.sv
module rstbusy_fifo #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RD_TAIL = rbf_pkg::RD_TAIL_DEFAULT
) (
  input  logic                     clk,
  input  logic                     srst,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     full,
  input  logic                     rd_en,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     wr_busy,
  output logic                     rd_busy,
  output logic                     proto_err
);
  localparam int unsigned AW = $clog2(DEPTH);

  rbf_pkg::gate_t gate;
  logic           busy;
  logic           wr_fire;
  logic [AW-1:0]  waddr;
  logic [AW-1:0]  raddr;

  rbf_reset_seq #(.RD_TAIL(RD_TAIL)) seq_i (
    .clk       (clk),
    .srst      (srst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .busy      (busy),
    .gate      (gate),
    .proto_err (proto_err)
  );

  rbf_ptr_ctrl #(.AW(AW)) ptr_i (
    .clk     (clk),
    .srst    (srst),
    .wr_req  (wr_en),
    .rd_req  (rd_en),
    .gate    (gate),
    .wr_fire (wr_fire),
    .waddr   (waddr),
    .raddr   (raddr),
    .full    (full),
    .empty   (empty),
    .level   (level)
  );

  rbf_store #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

  assign wr_busy = busy;
  assign rd_busy = busy;
endmodule

// File: rtl/rbf_checker.sv
module rbf_checker #(
  parameter int unsigned DEPTH = 16
) (
  input logic                   clk,
  input logic                   srst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   full,
  input logic                   empty,
  input logic [$clog2(DEPTH):0] level,
  input logic                   wr_busy,
  input logic                   rd_busy,
  input logic                   proto_err
);
  logic started = 1'b0;

  always_ff @(posedge clk) begin
    if (srst) started <= 1'b1;
  end

  initial begin
    assert_depth_pow2_R8: assert (rbf_pkg::is_pow2(DEPTH) && DEPTH >= 2)
      else $error("DEPTH must be a power of two >= 2");
  end

  assert_busy_pair_R1: assert property (@(posedge clk) disable iff (!started)
    wr_busy == rd_busy);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!started)
    srst |=> wr_busy);

  assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!started)
    !srst |=> !wr_busy);

  assert_reset_clears_R3: assert property (@(posedge clk) disable iff (!started)
    srst |=> (empty && !full && level == '0));

  assert_wr_misuse_R4: assert property (@(posedge clk) disable iff (!started)
    (wr_en && (srst || wr_busy)) |=> proto_err);

  assert_rd_misuse_R5: assert property (@(posedge clk) disable iff (!started)
    (rd_en && (srst || rd_busy)) |=> proto_err);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!started || srst)
    (full && wr_en && !rd_en) |=> (full && $stable(level)));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!started || srst)
    (empty && rd_en && !wr_en) |=> empty);

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!started)
    !(empty && full));
endmodule

bind rstbusy_fifo rbf_checker #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .srst      (srst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .full      (full),
  .empty     (empty),
  .level     (level),
  .wr_busy   (wr_busy),
  .rd_busy   (rd_busy),
  .proto_err (proto_err)
);

// File: tb/rstbusy_fifo_tb_top.sv
module rstbusy_fifo_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          srst = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic          full, empty, wr_busy, rd_busy, proto_err;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] level;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // Reference state, built from the requirements.
  logic [DW-1:0] mq[$];
  bit            busy_m  = 1'b0;
  int            quiet_m = 0;
  bit            err_m   = 1'b0;

  always #5 clk = ~clk;

  rstbusy_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .srst(srst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .level(level),
    .wr_busy(wr_busy), .rd_busy(rd_busy), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit we, input logic [DW-1:0] wd, input bit re);
    bit    wblk, rblk, do_w, do_r;
    string err_tag, lvl_tag;
    @(negedge clk);
    srst = s; wr_en = we; wr_data = wd; rd_en = re;
    // Windows from R4/R5: reset or busy, then one more cycle for writes,
    // and that cycle plus two more for reads.
    wblk = s || busy_m || (quiet_m == 3);
    rblk = s || busy_m || (quiet_m != 0);
    err_tag = (we && wblk) ? "R4" : ((re && rblk) ? "R5" : "R6");
    err_m = (we && wblk) || (re && rblk);
    do_w = !s && we && !wblk && (mq.size() < DEPTH);
    do_r = !s && re && !rblk && (mq.size() > 0);
    lvl_tag = s ? "R3" : ((do_w && do_r) ? "R10" : "R11");
    if (s) mq.delete();
    else begin
      if (do_r) void'(mq.pop_front());
      if (do_w) mq.push_back(wd);
    end
    quiet_m = (s || busy_m) ? 3 : ((quiet_m > 0) ? quiet_m - 1 : 0);
    busy_m  = s;
    @(posedge clk);
    #1;
    chk("R2 wr_busy", int'(wr_busy), int'(busy_m));
    chk("R1 rd_busy", int'(rd_busy), int'(wr_busy));
    chk({err_tag, " proto_err"}, int'(proto_err), int'(err_m));
    chk({lvl_tag, " level"}, int'(level), mq.size());
    chk(s ? "R3 empty" : "R9 empty", int'(empty), int'(mq.size() == 0));
    chk(s ? "R3 full" : "R8 full", int'(full), int'(mq.size() == DEPTH));
    if (mq.size() > 0) chk("R7 rd_data", int'(rd_data), int'(mq[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // Reset state.
    repeat (3) step(1'b1, 1'b0, '0, 1'b0);
    repeat (4) step(1'b0, 1'b0, '0, 1'b0);

    // R4: writes in the reset cycle, the busy cycle and the first quiet cycle.
    step(1'b1, 1'b1, 8'h11, 1'b0);
    step(1'b0, 1'b1, 8'h22, 1'b0);
    step(1'b0, 1'b1, 8'h33, 1'b0);
    // R5: reads in the two tail cycles, then a legal read of an empty buffer (R9).
    step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1);
    step(1'b0, 1'b0, '0, 1'b1);

    // R8: fill past capacity.
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b1, 8'(8'hA0 + i), 1'b0);
    // R8: read and write together while full, so the write is dropped.
    step(1'b0, 1'b1, 8'h5A, 1'b1);
    // R10: read and write together with room left.
    step(1'b0, 1'b1, 8'h5B, 1'b1);
    // R9: drain past empty.
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 1'b0, '0, 1'b1);

    // R2/R3: long reset in the middle of a fill.
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'(8'h30 + i), 1'b0);
    repeat (6) step(1'b1, 1'b0, '0, 1'b0);
    repeat (3) step(1'b0, 1'b0, '0, 1'b0);

    // Random traffic with occasional resets.
    for (int i = 0; i < 4000; i++) begin
      bit s, we, re;
      s  = ($urandom % 50) == 0;
      we = ($urandom % 100) < 55;
      re = ($urandom % 100) < 45;
      step(s, we, 8'($urandom), re);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule